// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This block decides which clock domains of a small controller system receive a clock, and when a low-power state starts and stops. Software sets one of two mode bits to leave normal running. The light state (idle) stops only the processor, acquisition and display domains. In this state the oscillator and the peripheral domains keep running. The deep state (power-down) stops the oscillator and every domain.

Wake requests, an analog-compare pulse and an external reset end these states. Each state has its own rules for which of these is accepted. After power-down, the domain clocks stay off for a settle window while the oscillator restarts. An external reset takes effect only once it has been held long enough. A warning pulse flags any entry into a low-power state while the watchdog is enabled.

`clk_i` is the always-running wake clock. All enables are registered on its rising edge.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After `rst_ni` is released, all eight clock enables are high, `osc_en_o` is high, `ctrl_rdata_o` is 2'b00, and `core_rst_o` and `wdt_warn_o` are low.
- R2: In run, a write with bit 0 (idle) set and bit 1 clear enters idle at that edge. `ctrl_rdata_o` then reads 2'b01 and `clk_en_o` reads 8'hF8. The enable bits are ordered processor 0, acquisition 1, display 2, memory 3, I2C 4, timers 5, watchdog 6, PWM 7. `osc_en_o` stays high.
- R3: In idle, an enabled request (a nonzero `irq_req_i & irq_en_i`) or `cmp_wake_i` returns to run at the edge where it is sampled. The idle bit clears and all enables go high. A request whose enable bit is 0 has no effect.
- R4: In run, a write with bit 1 (power-down) set enters power-down at that edge, even if bit 0 is also set. `ctrl_rdata_o` then reads 2'b10, `clk_en_o` reads 8'h00 and `osc_en_o` is low.
- R5: In power-down, only three inputs end the state: `ext_irq_i` while `ext_irq_lvl_i` is 1, `cmp_wake_i`, or `ext_rst_i`. `ext_irq_i` with `ext_irq_lvl_i` at 0 is ignored, and so is `irq_req_i`.
- R6: A power-down wake raises `osc_en_o` and clears the power-down bit at the wake edge. `clk_en_o` then stays 8'h00 for `SETTLE_CYCLES` cycles before all enables go high.
- R7: `ext_rst_i` held high for `CLKS_PER_MC*RST_MC` consecutive edges while the oscillator runs raises `core_rst_o`, clears both mode bits and sets all enables high. `core_rst_o` stays high until `ext_rst_i` drops. A shorter pulse has no effect.
- R8: Mode writes are accepted only in run. A write with both bits clear, or any write in idle, leaves the state unchanged.
- R9: Entering idle or power-down with `wdt_en_i` high gives a one-cycle pulse on `wdt_warn_o`. Entering with `wdt_en_i` low gives none.
- R10: When reset qualification falls on the same edge as a mode write, the reset result wins: run, both mode bits clear, `core_rst_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running wake clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Mode register write strobe |
| ctrl_wdata_i | input | 2 | Bit 0 idle, bit 1 power-down |
| ctrl_rdata_o | output | 2 | Current mode bits |
| irq_req_i | input | N_IRQ | Interrupt requests |
| irq_en_i | input | N_IRQ | Interrupt enables |
| ext_irq_i | input | 1 | External interrupt line |
| ext_irq_lvl_i | input | 1 | 1: external interrupt is level sensitive |
| cmp_wake_i | input | 1 | Analog-compare wake pulse |
| ext_rst_i | input | 1 | External reset request |
| wdt_en_i | input | 1 | Watchdog enabled |
| clk_en_o | output | 8 | Per-domain clock enables |
| osc_en_o | output | 1 | Oscillator run enable |
| core_rst_o | output | 1 | Qualified reset to processor, display and registers |
| wdt_warn_o | output | 1 | Low-power entry with watchdog enabled |

## Verification
Two events can land on the same edge: reset qualification and a mode write. The bench holds `ext_rst_i` for one edge less than the qualifying length. It then strobes a write of the idle bit so that the write lands on the qualifying edge. The result counts as correct only if the block stays in run with both bits clear, `core_rst_o` high and every enable high. The same edge-alignment approach also checks that a 23-edge pulse in idle leaves the mode untouched.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_IDLE, ST_PDOWN, ST_SETTLE} pmode_e;

  localparam int NUM_DOM  = 8;
  localparam int DOM_CPU  = 0;
  localparam int DOM_ACQ  = 1;
  localparam int DOM_DISP = 2;
  localparam int DOM_MEM  = 3;
  localparam int DOM_I2C  = 4;
  localparam int DOM_TMR  = 5;
  localparam int DOM_WDT  = 6;
  localparam int DOM_PWM  = 7;

  localparam logic [NUM_DOM-1:0] IDLE_KEEP =
    (NUM_DOM'(1) << DOM_MEM) | (NUM_DOM'(1) << DOM_I2C) | (NUM_DOM'(1) << DOM_TMR) |
    (NUM_DOM'(1) << DOM_WDT) | (NUM_DOM'(1) << DOM_PWM);

  localparam int MODE_IDL = 0;
  localparam int MODE_PD  = 1;
endpackage

// File: rtl/pgc_wake_qual.sv
module pgc_wake_qual import pgc_pkg::*; #(
  parameter int N_IRQ = 8
) (
  input  pmode_e           mode_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             ext_irq_i,
  input  logic             ext_irq_lvl_i,
  input  logic             cmp_wake_i,
  input  logic             ext_rst_i,
  output logic             idle_wake_o,
  output logic             pd_wake_o
);
  logic any_irq;
  logic lvl_irq;

  assign any_irq = |(irq_req_i & irq_en_i);
  // no clock runs in power-down, so only a held level can be seen
  assign lvl_irq = ext_irq_i & ext_irq_lvl_i;

  always_comb begin
    idle_wake_o = 1'b0;
    pd_wake_o   = 1'b0;
    if (mode_i == ST_IDLE)  idle_wake_o = any_irq | cmp_wake_i;
    if (mode_i == ST_PDOWN) pd_wake_o   = lvl_irq | cmp_wake_i | ext_rst_i;
  end
endmodule

// File: rtl/pgc_rst_filter.sv
module pgc_rst_filter #(
  parameter int RST_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic osc_run_i,
  output logic hit_o,
  output logic held_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          held_q;

  assign hit_o  = ext_rst_i & osc_run_i & ~held_q & (cnt_q == CW'(RST_CYCLES - 1));
  assign held_o = held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (!ext_rst_i) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (hit_o) begin
      held_q <= 1'b1;
    end else if (osc_run_i && !held_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_rst_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> $past(ext_rst_i) && $past(cnt_q) == CW'(RST_CYCLES - 1));
  p_rst_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_i |=> !held_q);
endmodule

// File: rtl/pgc_settle_timer.sv
module pgc_settle_timer #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic last_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(SETTLE_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_q + 1'b1;
  end

  p_settle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !last_o) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl import pgc_pkg::*; #(
  parameter int N_IRQ         = 8,
  parameter int SETTLE_CYCLES = 16,
  parameter int CLKS_PER_MC   = 12,
  parameter int RST_MC        = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [1:0]         ctrl_wdata_i,
  output logic [1:0]         ctrl_rdata_o,
  input  logic [N_IRQ-1:0]   irq_req_i,
  input  logic [N_IRQ-1:0]   irq_en_i,
  input  logic               ext_irq_i,
  input  logic               ext_irq_lvl_i,
  input  logic               cmp_wake_i,
  input  logic               ext_rst_i,
  input  logic               wdt_en_i,
  output logic [NUM_DOM-1:0] clk_en_o,
  output logic               osc_en_o,
  output logic               core_rst_o,
  output logic               wdt_warn_o
);
  localparam int RST_CYCLES = CLKS_PER_MC * RST_MC;

  pmode_e state_q, state_d;
  logic   idle_wake, pd_wake;
  logic   rst_hit, rst_held, settle_last;
  logic   osc_q, warn_q;
  logic   lp_entry;

  pgc_wake_qual #(.N_IRQ(N_IRQ)) u_wake (
    .mode_i       (state_q),
    .irq_req_i    (irq_req_i),
    .irq_en_i     (irq_en_i),
    .ext_irq_i    (ext_irq_i),
    .ext_irq_lvl_i(ext_irq_lvl_i),
    .cmp_wake_i   (cmp_wake_i),
    .ext_rst_i    (ext_rst_i),
    .idle_wake_o  (idle_wake),
    .pd_wake_o    (pd_wake)
  );

  pgc_rst_filter #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_rst_i(ext_rst_i),
    .osc_run_i(osc_q),
    .hit_o    (rst_hit),
    .held_o   (rst_held)
  );

  pgc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q != ST_SETTLE),
    .last_o (settle_last)
  );

  always_comb begin
    state_d = state_q;
    if (rst_hit || rst_held) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          // power-down outranks idle when both bits are written
          if (ctrl_we_i && ctrl_wdata_i[MODE_PD])       state_d = ST_PDOWN;
          else if (ctrl_we_i && ctrl_wdata_i[MODE_IDL]) state_d = ST_IDLE;
        end
        ST_IDLE:   if (idle_wake)   state_d = ST_RUN;
        ST_PDOWN:  if (pd_wake)     state_d = ST_SETTLE;
        ST_SETTLE: if (settle_last) state_d = ST_RUN;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  assign lp_entry = (state_q == ST_RUN) && (state_d == ST_IDLE || state_d == ST_PDOWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      osc_q   <= 1'b1;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      osc_q   <= (state_d != ST_PDOWN);
      warn_q  <= lp_entry & wdt_en_i;
    end
  end

  // one registered enable per domain; idle keeps the IDLE_KEEP set alive
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b1;
      else         en_q <= (state_d == ST_RUN) || (state_d == ST_IDLE && IDLE_KEEP[d]);
    end
    assign clk_en_o[d] = en_q;
  end

  assign osc_en_o                = osc_q;
  assign ctrl_rdata_o[MODE_IDL]  = (state_q == ST_IDLE);
  assign ctrl_rdata_o[MODE_PD]   = (state_q == ST_PDOWN);
  assign core_rst_o              = rst_held;
  assign wdt_warn_o              = warn_q;

  p_idle_gates_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o == 2'b01 |-> clk_en_o == IDLE_KEEP && osc_en_o);
  p_idle_wake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && (|(irq_req_i & irq_en_i) || cmp_wake_i)) |=> &clk_en_o);
  p_pd_dark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[MODE_PD] |-> !osc_en_o && clk_en_o == '0);
  p_bits_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_rdata_o));
  p_edge_no_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PDOWN && !(ext_irq_i && ext_irq_lvl_i) && !cmp_wake_i && !ext_rst_i)
      |=> ctrl_rdata_o[MODE_PD]);
  p_settle_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SETTLE |-> osc_en_o && clk_en_o == '0);
  p_core_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> ctrl_rdata_o == 2'b00 && &clk_en_o);
  p_wdt_warn_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_warn_o |-> $past(wdt_en_i) && ctrl_rdata_o != 2'b00);
endmodule

// File: tb/pwr_gate_ctrl_tb.sv
module pwr_gate_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ      = 8;
  localparam int SETTLE     = 5;
  localparam int RST_LEN    = 24;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             ctrl_we;
  logic [1:0]       ctrl_wdata;
  logic [1:0]       ctrl_rdata;
  logic [N_IRQ-1:0] irq_req, irq_en;
  logic             ext_irq, ext_lvl, cmp_wake, ext_rst, wdt_en;
  logic [7:0]       clk_en;
  logic             osc_en, core_rst, wdt_warn;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_gate_ctrl #(.N_IRQ(N_IRQ), .SETTLE_CYCLES(SETTLE), .CLKS_PER_MC(12), .RST_MC(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rdata_o(ctrl_rdata), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .ext_irq_i(ext_irq), .ext_irq_lvl_i(ext_lvl), .cmp_wake_i(cmp_wake),
    .ext_rst_i(ext_rst), .wdt_en_i(wdt_en), .clk_en_o(clk_en), .osc_en_o(osc_en),
    .core_rst_o(core_rst), .wdt_warn_o(wdt_warn)
  );

  // 0 run, 1 idle, 2 power-down or settling
  function automatic logic [7:0] exp_en(input int m);
    return (m == 0) ? 8'hFF : (m == 1) ? 8'hF8 : 8'h00;
  endfunction

  function automatic logic [1:0] exp_bits(input int m);
    return (m == 1) ? 2'b01 : (m == 2) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input int m);
    chk(req, {24'd0, clk_en}, {24'd0, exp_en(m)});
    chk(req, {30'd0, ctrl_rdata}, {30'd0, exp_bits(m)});
    chk(req, {31'd0, osc_en}, {31'd0, m != 2});
  endtask

  task automatic write_mode(input logic [1:0] v, input logic wd);
    ctrl_we = 1'b1; ctrl_wdata = v; wdt_en = wd;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = 2'b00;
  endtask

  task automatic pulse_cmp();
    cmp_wake = 1'b1;
    @(negedge clk);
    cmp_wake = 1'b0;
  endtask

  task automatic check_settle(input string req);
    for (int i = 1; i < SETTLE; i++) begin
      @(negedge clk);
      chk(req, {24'd0, clk_en}, 32'h0);
    end
    @(negedge clk);
    chk(req, {24'd0, clk_en}, 32'hFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    rst_ni = 1'b0; ctrl_we = 1'b0; ctrl_wdata = 2'b00;
    irq_req = '0; irq_en = '0; ext_irq = 1'b0; ext_lvl = 1'b0;
    cmp_wake = 1'b0; ext_rst = 1'b0; wdt_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_mode("R1", 0);
    chk("R1", {31'd0, core_rst}, 32'd0);
    chk("R1", {31'd0, wdt_warn}, 32'd0);

    // R8 write of zero bits
    write_mode(2'b00, 1'b0);
    chk_mode("R8", 0);

    // R4 both bits, R9 warn pulse
    write_mode(2'b11, 1'b1);
    chk_mode("R4", 2);
    chk("R9", {31'd0, wdt_warn}, 32'd1);
    wdt_en = 1'b0;
    @(negedge clk);
    chk("R9", {31'd0, wdt_warn}, 32'd0);

    // R5 edge-configured external irq and irq vector are ignored
    ext_irq = 1'b1; ext_lvl = 1'b0; irq_req = '1; irq_en = '1;
    repeat (3) @(negedge clk);
    chk_mode("R5", 2);
    ext_irq = 1'b0; irq_req = '0; irq_en = '0;

    // R6 compare wake and settle window
    pulse_cmp();
    chk("R6", {31'd0, osc_en}, 32'd1);
    chk("R6", {30'd0, ctrl_rdata}, 32'd0);
    chk("R6", {24'd0, clk_en}, 32'd0);
    check_settle("R6");

    // R2 idle, R9 no warn
    write_mode(2'b01, 1'b0);
    chk_mode("R2", 1);
    chk("R9", {31'd0, wdt_warn}, 32'd0);
    // R8 write in idle ignored
    write_mode(2'b10, 1'b0);
    chk_mode("R8", 1);
    // R3 disabled request has no effect
    irq_req = 8'hA5; irq_en = 8'h5A;
    @(negedge clk);
    chk_mode("R3", 1);
    irq_req = '0; irq_en = '0;

    // R7 short pulse in idle
    ext_rst = 1'b1;
    repeat (RST_LEN - 1) @(negedge clk);
    ext_rst = 1'b0;
    @(negedge clk);
    chk_mode("R7", 1);
    chk("R7", {31'd0, core_rst}, 32'd0);
    // R7 full pulse in idle
    ext_rst = 1'b1;
    repeat (RST_LEN - 1) @(negedge clk);
    chk("R7", {31'd0, core_rst}, 32'd0);
    @(negedge clk);
    chk("R7", {31'd0, core_rst}, 32'd1);
    chk_mode("R7", 0);
    ext_rst = 1'b0;
    @(negedge clk);
    chk("R7", {31'd0, core_rst}, 32'd0);

    // R10 qualification and write on the same edge
    ext_rst = 1'b1;
    repeat (RST_LEN - 1) @(negedge clk);
    write_mode(2'b01, 1'b0);
    chk("R10", {31'd0, core_rst}, 32'd1);
    chk_mode("R10", 0);
    ext_rst = 1'b0;
    @(negedge clk);
    chk_mode("R10", 0);

    // R7 reset ends power-down
    write_mode(2'b10, 1'b0);
    ext_rst = 1'b1;
    repeat (RST_LEN + 4) @(negedge clk);
    chk("R7", {31'd0, core_rst}, 32'd1);
    chk_mode("R7", 0);
    ext_rst = 1'b0;
    @(negedge clk);

    // random rounds
    for (int it = 0; it < 40; it++) begin
      logic wd;
      wd = 1'($urandom);
      if ($urandom % 2 == 0) begin
        logic [N_IRQ-1:0] rq, en;
        logic cw, wake;
        write_mode(2'b01, wd);
        chk_mode("R2", 1);
        chk("R9", {31'd0, wdt_warn}, {31'd0, wd});
        rq = N_IRQ'($urandom); en = N_IRQ'($urandom) & N_IRQ'($urandom);
        cw = ($urandom % 4 == 0);
        wake = (|(rq & en)) | cw;
        irq_req = rq; irq_en = en; cmp_wake = cw;
        @(negedge clk);
        irq_req = '0; irq_en = '0; cmp_wake = 1'b0;
        chk_mode("R3", wake ? 0 : 1);
        if (!wake) begin
          pulse_cmp();
          chk_mode("R3", 0);
        end
      end else begin
        logic ei, lv, cw, wake;
        write_mode({1'b1, 1'($urandom)}, wd);
        chk_mode("R4", 2);
        chk("R9", {31'd0, wdt_warn}, {31'd0, wd});
        ei = 1'($urandom); lv = 1'($urandom); cw = ($urandom % 4 == 0);
        wake = (ei & lv) | cw;
        ext_irq = ei; ext_lvl = lv; cmp_wake = cw;
        irq_req = N_IRQ'($urandom); irq_en = '1;
        @(negedge clk);
        ext_irq = 1'b0; ext_lvl = 1'b0; cmp_wake = 1'b0; irq_req = '0; irq_en = '0;
        if (wake) begin
          chk("R5", {30'd0, ctrl_rdata}, 32'd0);
          check_settle("R6");
        end else begin
          chk_mode("R5", 2);
          pulse_cmp();
          check_settle("R6");
        end
      end
      wdt_en = 1'b0;
      @(negedge clk);
    end

    finish_run();
  end
endmodule